// File: doc/BRIEF.md
# Configurable Input Capture Cell

The cell conditions a group of input pins before they reach the logic array. A static mode input picks one of three paths: a combinational pass-through, an edge-triggered register, or a level-sensitive latch. Register and latch share one capture clock.

That capture clock is taken from one of two dedicated clock pins or from an internally generated logic clock. A polarity bit can invert it. When inverted, the register captures on falling edges and the latch is open while the clock is low. An asynchronous active-low reset clears both storage elements.

The configuration inputs are meant to be held static in normal use. The clock selector and the inversion are modelled as a simple multiplexer and an XOR. Changing them while a clock is running can therefore create an extra edge.

Top module: `input_capture_cell`

## Requirements
- R1: With mode code 00, cap_o equals pin_i combinationally, with no clock involved.
- R2: Mode code 11 behaves exactly like mode code 00 (pass-through).
- R3: With mode code 01 and the clock not inverted, cap_o takes the value of pin_i at each rising edge of the selected clock. It holds through the falling edge and through input changes between edges.
- R4: With mode code 01 and clk_inv_i = 1, capture happens on falling edges of the selected clock and rising edges have no effect.
- R5: Clock select code 01 uses clk2_i. Edges on clk1_i and pclk_i then cause no capture.
- R6: Clock select code 10 uses pclk_i. Edges on clk1_i and clk2_i then cause no capture.
- R7: Clock select code 11 uses clk1_i. Edges on clk2_i and pclk_i then cause no capture.
- R8: While rst_ni is low, the register and the latch are both 0, independent of any clock. Register or latch mode then shows 0 on cap_o, and the latch still shows 0 after release until it next opens.
- R9: With mode code 10 and the clock not inverted, cap_o follows pin_i while the selected clock is high and holds the last value from the falling edge until the clock rises again.
- R10: With mode code 10 and clk_inv_i = 1, the latch is open while the selected clock is low and holds while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk1_i | input | 1 | Dedicated clock pin 1 |
| clk2_i | input | 1 | Dedicated clock pin 2 |
| pclk_i | input | 1 | Internally generated logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset of register and latch |
| mode_i | input | 2 | Path select: 00 bypass, 01 register, 10 latch, 11 bypass |
| clk_sel_i | input | 2 | Clock source: 00 clk1, 01 clk2, 10 pclk, 11 clk1 |
| clk_inv_i | input | 1 | Inverts the selected capture clock |
| pin_i | input | WIDTH | Input pins to condition |
| cap_o | output | WIDTH | Conditioned value toward the logic array |

## Verification
The bench builds the cell with its default WIDTH of 4. Each scenario can then use a distinct nibble, so a value from a stale edge or from the wrong storage element is never mistaken for the expected one. A single width-independent path through the cell is all the logic has, so a wider build adds no new corner. The dedicated clock 2 and the logic clock are pulsed by hand between edges of the free-running clock 1. This makes it possible to show, for each select code, that the clocks not chosen cause no capture.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    MODE_BYP = 2'b00,
    MODE_REG = 2'b01,
    MODE_LAT = 2'b10,
    MODE_RSV = 2'b11
  } cap_mode_e;

  typedef enum logic [1:0] {
    SRC_CLK1 = 2'b00,
    SRC_CLK2 = 2'b01,
    SRC_PCLK = 2'b10,
    SRC_RSV  = 2'b11
  } clk_src_e;

endpackage

// File: rtl/icc_clk_sel.sv
module icc_clk_sel
  import icc_pkg::*;
(
  input  logic     clk1_i,
  input  logic     clk2_i,
  input  logic     pclk_i,
  input  clk_src_e sel_i,
  input  logic     inv_i,
  output logic     cap_clk_o
);

  logic raw_clk;

  // behavioural mux; not a glitch-free switch
  always_comb begin
    case (sel_i)
      SRC_CLK2: raw_clk = clk2_i;
      SRC_PCLK: raw_clk = pclk_i;
      default:  raw_clk = clk1_i;
    endcase
  end

  assign cap_clk_o = raw_clk ^ inv_i;

endmodule

// File: rtl/icc_capture_reg.sv
module icc_capture_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/icc_capture_latch.sv
module icc_capture_latch #(
  parameter int WIDTH = 4
) (
  input  logic             en_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (en_i) q_o = d_i;
  end

endmodule

// File: rtl/icc_path_mux.sv
module icc_path_mux
  import icc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cap_mode_e        mode_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] reg_q_i,
  input  logic [WIDTH-1:0] lat_q_i,
  output logic [WIDTH-1:0] cap_o
);

  always_comb begin
    case (mode_i)
      MODE_REG: cap_o = reg_q_i;
      MODE_LAT: cap_o = lat_q_i;
      default:  cap_o = pin_i;  // MODE_BYP and MODE_RSV
    endcase
  end

endmodule

// File: rtl/input_capture_cell.sv
module input_capture_cell
  import icc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk1_i,
  input  logic             clk2_i,
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             clk_inv_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] cap_o
);

  logic             cap_clk;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] lat_q;

  icc_clk_sel i_clk_sel (
    .clk1_i    (clk1_i),
    .clk2_i    (clk2_i),
    .pclk_i    (pclk_i),
    .sel_i     (clk_src_e'(clk_sel_i)),
    .inv_i     (clk_inv_i),
    .cap_clk_o (cap_clk)
  );

  icc_capture_reg #(.WIDTH(WIDTH)) i_capture_reg (
    .clk_i  (cap_clk),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (reg_q)
  );

  icc_capture_latch #(.WIDTH(WIDTH)) i_capture_latch (
    .en_i   (cap_clk),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lat_q)
  );

  icc_path_mux #(.WIDTH(WIDTH)) i_path_mux (
    .mode_i  (cap_mode_e'(mode_i)),
    .pin_i   (pin_i),
    .reg_q_i (reg_q),
    .lat_q_i (lat_q),
    .cap_o   (cap_o)
  );

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk1_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [1:0]       clk_sel_i,
  input logic             clk_inv_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] cap_o
);

  logic [1:0] age;

  always_ff @(posedge clk1_i or negedge rst_ni) begin
    if (!rst_ni)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_bypass_pass_R1: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (cap_o == pin_i));

  assert_rsv_bypass_R2: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (cap_o == pin_i));

  assert_reg_rise_R3: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (age >= 2'd2 && mode_i == 2'b01 && clk_sel_i == 2'b00 && !clk_inv_i &&
     $stable(mode_i) && $stable(clk_sel_i) && $stable(clk_inv_i))
    |-> (cap_o == $past(pin_i)));

  assert_reg_fall_R4: assert property (@(negedge clk1_i) disable iff (!rst_ni)
    (age >= 2'd2 && mode_i == 2'b01 && clk_sel_i == 2'b00 && clk_inv_i &&
     $stable(mode_i) && $stable(clk_sel_i) && $stable(clk_inv_i))
    |-> (cap_o == $past(pin_i)));

  assert_reset_clear_R8: assert property (@(posedge clk1_i)
    (!rst_ni && (mode_i == 2'b01 || mode_i == 2'b10)) |-> (cap_o == '0));

  assert_latch_open_R9: assert property (@(negedge clk1_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && clk_sel_i == 2'b00 && !clk_inv_i) |-> (cap_o == pin_i));

  assert_latch_open_inv_R10: assert property (@(posedge clk1_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && clk_sel_i == 2'b00 && clk_inv_i) |-> (cap_o == pin_i));

endmodule

bind input_capture_cell icc_checker #(.WIDTH(WIDTH)) i_icc_checker (
  .clk1_i    (clk1_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .clk_sel_i (clk_sel_i),
  .clk_inv_i (clk_inv_i),
  .pin_i     (pin_i),
  .cap_o     (cap_o)
);

// File: tb/test_input_capture_cell.sv
module test_input_capture_cell;

  localparam int W = 4;

  logic         clk1_i = 1'b0;
  logic         clk2_i = 1'b0;
  logic         pclk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [1:0]   mode_i = 2'b00;
  logic [1:0]   clk_sel_i = 2'b00;
  logic         clk_inv_i = 1'b0;
  logic [W-1:0] pin_i = '0;
  logic [W-1:0] cap_o;

  int checks = 0;
  int errors = 0;

  input_capture_cell #(.WIDTH(W)) i_input_capture_cell (
    .clk1_i    (clk1_i),
    .clk2_i    (clk2_i),
    .pclk_i    (pclk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .clk_sel_i (clk_sel_i),
    .clk_inv_i (clk_inv_i),
    .pin_i     (pin_i),
    .cap_o     (cap_o)
  );

  always #5 clk1_i = ~clk1_i;

  task automatic chk(input string tag, input logic [W-1:0] exp);
    checks++;
    if (cap_o !== exp) begin
      errors++;
      $display("FAIL %s: cap_o=%h expected %h", tag, cap_o, exp);
    end
  endtask

  task automatic pulse_clk2();
    #1 clk2_i = 1'b1;
    #1 clk2_i = 1'b0;
  endtask

  task automatic pulse_pclk();
    #1 pclk_i = 1'b1;
    #1 pclk_i = 1'b0;
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    mode_i = 2'b01; pin_i = 4'hA;
    repeat (2) @(posedge clk1_i);
    #1 chk("R8 reg in reset", 4'h0);
    mode_i = 2'b10;
    #1 chk("R8 latch in reset", 4'h0);
    @(negedge clk1_i); #2;
    mode_i = 2'b00;
    rst_ni = 1'b1;
  endtask

  task automatic t_bypass();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; pin_i = 4'h5;
    #1 chk("R1 bypass 5", 4'h5);
    pin_i = 4'hC;
    #1 chk("R1 bypass C", 4'hC);
    mode_i = 2'b11; pin_i = 4'h9;
    #1 chk("R2 code 11 bypass", 4'h9);
    pin_i = 4'h2;
    #1 chk("R2 code 11 follows", 4'h2);
  endtask

  task automatic t_register();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_sel_i = 2'b00; clk_inv_i = 1'b0;
    pin_i = 4'h3; mode_i = 2'b01;
    @(posedge clk1_i); #1 chk("R3 rise capture", 4'h3);
    pin_i = 4'h6;
    #2 chk("R3 hold between edges", 4'h3);
    @(negedge clk1_i); #1 chk("R3 fall ignored", 4'h3);
    @(posedge clk1_i); #1 chk("R3 next rise", 4'h6);
  endtask

  task automatic t_reg_inv();
    @(posedge clk1_i); #1;
    mode_i = 2'b00; clk_inv_i = 1'b1; pin_i = 4'h7; mode_i = 2'b01;
    @(negedge clk1_i); #1 chk("R4 fall capture", 4'h7);
    pin_i = 4'h8;
    @(posedge clk1_i); #1 chk("R4 rise ignored", 4'h7);
    @(negedge clk1_i); #1 chk("R4 next fall", 4'h8);
  endtask

  task automatic t_clk2();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_inv_i = 1'b0; clk_sel_i = 2'b01; mode_i = 2'b01;
    pin_i = 4'hA;
    pulse_clk2();
    #1 chk("R5 clk2 capture", 4'hA);
    pin_i = 4'hB;
    pulse_pclk();
    repeat (2) @(posedge clk1_i);
    #1 chk("R5 clk1 and pclk ignored", 4'hA);
    pulse_clk2();
    #1 chk("R5 clk2 second capture", 4'hB);
  endtask

  task automatic t_pclk();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_sel_i = 2'b10; mode_i = 2'b01;
    pin_i = 4'h4;
    pulse_pclk();
    #1 chk("R6 pclk capture", 4'h4);
    pin_i = 4'hC;
    pulse_clk2();
    repeat (2) @(posedge clk1_i);
    #1 chk("R6 clk1 and clk2 ignored", 4'h4);
    pulse_pclk();
    #1 chk("R6 pclk second capture", 4'hC);
  endtask

  task automatic t_sel_rsv();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_sel_i = 2'b11; mode_i = 2'b01;
    pin_i = 4'hD;
    @(posedge clk1_i); #1 chk("R7 code 11 uses clk1", 4'hD);
    pin_i = 4'hE;
    pulse_clk2();
    pulse_pclk();
    #1 chk("R7 clk2 and pclk ignored", 4'hD);
    @(posedge clk1_i); #1 chk("R7 clk1 next rise", 4'hE);
  endtask

  task automatic t_latch();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_sel_i = 2'b00; clk_inv_i = 1'b0;
    @(posedge clk1_i); #1;
    pin_i = 4'h1; mode_i = 2'b10;
    #1 chk("R9 open while high", 4'h1);
    pin_i = 4'h2;
    #1 chk("R9 follows while high", 4'h2);
    @(negedge clk1_i); #1 chk("R9 held at fall", 4'h2);
    pin_i = 4'h3;
    #1 chk("R9 holds while low", 4'h2);
    @(posedge clk1_i); #1 chk("R9 reopens", 4'h3);
  endtask

  task automatic t_latch_inv();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_inv_i = 1'b1;
    pin_i = 4'h4; mode_i = 2'b10;
    #1 chk("R10 open while low", 4'h4);
    @(posedge clk1_i); #1;
    pin_i = 4'h5;
    #1 chk("R10 holds while high", 4'h4);
    @(negedge clk1_i); #1 chk("R10 reopens", 4'h5);
  endtask

  task automatic t_async_reset();
    @(negedge clk1_i); #1;
    mode_i = 2'b00; clk_inv_i = 1'b0; clk_sel_i = 2'b00;
    pin_i = 4'hF; mode_i = 2'b01;
    @(posedge clk1_i); #1 chk("R3 captured before reset", 4'hF);
    rst_ni = 1'b0;
    #1 chk("R8 async clear register", 4'h0);
    mode_i = 2'b10;
    #1 chk("R8 latch held clear while clock high", 4'h0);
    @(negedge clk1_i); #1;
    rst_ni = 1'b1;
    #1 chk("R8 latch cleared after release", 4'h0);
    mode_i = 2'b01;
    #1 chk("R8 register cleared after release", 4'h0);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_register();
    t_reg_inv();
    t_clk2();
    t_pclk();
    t_sel_rsv();
    t_latch();
    t_latch_inv();
    t_async_reset();
    #20;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule